// File: doc/BRIEF.md
# Fractional-Rate Microsecond Timebase

This block turns an oscillator of any supported frequency into a free-running 32-bit microsecond count. On every enabled oscillator cycle, a fractional rate generator adds a programmable increment into an accumulator. Each time the accumulator passes a programmable modulus, the generator emits one tick. The ratio is expressed as (dividend+1) ticks per (divisor+1) oscillator cycles. Non-integer ratios such as 19.2 or 38.4 cycles per microsecond therefore average to exactly 1 MHz, and integer ratios behave as a plain divider.

Software sees two words in a small register window. The word at byte offset 0 is the live count and is read-only. The word at byte offset 4 holds the ratio. A clock-enable input, driven by an external clock controller, freezes the whole timebase while it is low. Writing the ratio restarts the fractional phase but leaves the count untouched, so reprogramming never makes time jump.

Top module: `usec_timebase`

## Requirements
- R1: After reset the count reads RESET_COUNT (default 0) and the ratio word reads 0x0000000C; reg_rdata is 0.
- R2: With the ratio word holding dividend q in bits 15:8 and divisor w in bits 7:0, and q <= w, N enabled cycles after a ratio write advance the count by floor(N*(q+1)/(w+1)).
- R3: Ratio 0x000B gives one tick per 12 enabled cycles, 0x0019 one per 26, and 0x002F one per 48.
- R4: Ratios 0x045F, 0x04BF and 0x0453 give exactly 5 ticks per 96, 192 and 84 enabled cycles respectively.
- R5: The reset ratio 0x000C gives one tick per 13 enabled cycles.
- R6: While clk_en is low, neither the count nor the fractional phase changes.
- R7: A write to the ratio word clears the fractional phase, does not change the count, and suppresses any tick in that cycle.
- R8: When q > w, the count advances by exactly one on every enabled cycle.
- R9: The count wraps from 0xFFFFFFFF to 0 and keeps running.
- R10: A read at offset 0 returns the count and a read at offset 4 returns the ratio in bits 15:0 with bits 31:16 zero. Any other offset reads 0. Writes to offset 0 are ignored. Read data appears in the cycle after reg_rd.
- R11: The count advances by at most one per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Gate from the external clock controller; the timebase runs only while high |
| reg_addr | input | 3 | Byte offset within the register window |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |

## Verification
A tick adds one to the count at the same clock edge as the enabled cycle that produces it. A ratio write takes effect at the edge that samples reg_wr. Read data is valid one cycle after reg_rd. The bench drives every input on the falling edge and counts enabled rising edges exactly. It holds clk_en low during register accesses, so each expected count is a closed-form function of the enabled-edge count since the last ratio write. It samples reg_rdata on the falling edge after the rising edge that captured the read.

// File: rtl/usec_pkg.sv
package usec_pkg;
    localparam int FIELD_W = 8;
    localparam int CFG_W   = 2 * FIELD_W;

    typedef struct packed {
        logic [FIELD_W-1:0] dividend;
        logic [FIELD_W-1:0] divisor;
    } rate_cfg_t;

    localparam rate_cfg_t CFG_RESET = '{dividend: '0, divisor: FIELD_W'(12)};
endpackage

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
    import usec_pkg::*;
#(
    parameter int ACC_W = FIELD_W + 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clk_en,
    input  logic      clear,
    input  rate_cfg_t cfg,
    output logic      tick
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic [ACC_W-1:0] inc, den, sum, rem;

    always_comb begin
        inc  = ACC_W'(cfg.dividend) + ACC_W'(1);
        den  = ACC_W'(cfg.divisor) + ACC_W'(1);
        sum  = st_q.acc + inc;
        rem  = sum - den;
        st_d = st_q;
        tick = 1'b0;
        if (clear) begin
            st_d.acc = '0;
        end else if (clk_en) begin
            if (sum >= den) begin
                tick     = 1'b1;
                // residue stays below the modulus; excess rate is dropped
                st_d.acc = (rem >= den) ? den - ACC_W'(1) : rem;
            end else begin
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc < den); // R2
    AST_CLEAR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> st_q.acc == '0); // R7
    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !clear) |=> $stable(st_q.acc)); // R6
    AST_SAT_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !clear && (inc > den)) |-> tick); // R8
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
    parameter int              CNT_W       = 32,
    parameter logic [CNT_W-1:0] RESET_COUNT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.cnt <= RESET_COUNT;
        else        st_q     <= st_d;
    end

    assign count = st_q.cnt;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count)) || (count == $past(count) + CNT_W'(1))); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count)); // R6
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (count == '1)) |=> count == '0); // R9
endmodule

// File: rtl/usec_regs.sv
module usec_regs
    import usec_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 32,
    parameter int CNT_OFF = 0,
    parameter int CFG_OFF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output rate_cfg_t         cfg,
    output logic              cfg_wr,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        rate_cfg_t         cfg;
        logic [DATA_W-1:0] rdata;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic hit_cnt, hit_cfg;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:CFG_W];

    always_comb begin
        hit_cnt = (addr == ADDR_W'(CNT_OFF));
        hit_cfg = (addr == ADDR_W'(CFG_OFF));
        cfg_wr  = wr && hit_cfg;
        st_d    = st_q;
        if (cfg_wr) st_d.cfg = rate_cfg_t'(wdata[CFG_W-1:0]);
        if (rd) begin
            if (hit_cnt)      st_d.rdata = DATA_W'(count);
            else if (hit_cfg) st_d.rdata = DATA_W'(st_q.cfg);
            else              st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg   <= CFG_RESET;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg   = st_q.cfg;
    assign rdata = st_q.rdata;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !hit_cnt && !hit_cfg) |=> rdata == '0); // R10
    AST_COUNT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit_cnt) |=> rdata == DATA_W'($past(count))); // R10
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(cfg)); // R7
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
    import usec_pkg::*;
#(
    parameter int               ADDR_W      = 3,
    parameter int               DATA_W      = 32,
    parameter int               CNT_W       = 32,
    parameter logic [CNT_W-1:0] RESET_COUNT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int ACC_W = FIELD_W + 2;

    rate_cfg_t        cfg;
    logic             cfg_wr;
    logic             tick;
    logic [CNT_W-1:0] count;

    usec_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .CNT_OFF(0), .CFG_OFF(4)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
        .wdata(reg_wdata), .count(count), .cfg(cfg), .cfg_wr(cfg_wr),
        .rdata(reg_rdata)
    );

    frac_tick_gen #(.ACC_W(ACC_W)) u_gen (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .clear(cfg_wr),
        .cfg(cfg), .tick(tick)
    );

    usec_counter #(.CNT_W(CNT_W), .RESET_COUNT(RESET_COUNT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count(count)
    );

    AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(count)); // R6
    AST_WRITE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> $stable(count)); // R7
endmodule

// File: tb/usec_timebase_test.sv
module usec_timebase_test;
    localparam logic [31:0] START = 32'hFFFF_F000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] model = START;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    usec_timebase #(.RESET_COUNT(START)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run_en(input int n);
        @(negedge clk);
        clk_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        clk_en = 1'b0;
    endtask

    function automatic logic [31:0] advance(input logic [15:0] c, input int n);
        longint q = longint'(c[15:8]) + 1;
        longint w = longint'(c[7:0]) + 1;
        if (q > w) return 32'(n);
        return 32'((longint'(n) * q) / w);
    endfunction

    task automatic rate_case(input string req, input logic [15:0] c, input int n);
        logic [31:0] v;
        wr(3'd4, {16'h0, c});
        run_en(n);
        model = model + advance(c, n);
        rd(3'd0, v);
        check(req, v, model);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 rdata", reg_rdata, 32'h0);
        rd(3'd0, v); check("R1 count", v, START);
        rd(3'd4, v); check("R1 ratio", v, 32'h0000_000C);
    endtask

    task automatic t_map;
        logic [31:0] v;
        wr(3'd0, 32'h1234_5678);
        rd(3'd0, v); check("R10 count write ignored", v, model);
        rd(3'd2, v); check("R10 unmapped read", v, 32'h0);
        wr(3'd4, 32'hABCD_0C00);
        rd(3'd4, v); check("R10 ratio upper bits", v, 32'h0000_0C00);
        wr(3'd4, 32'h0000_000C);
        rd(3'd0, v); check("R7 write keeps count", v, model);
    endtask

    task automatic t_default;
        logic [31:0] v;
        run_en(130);
        model = model + 32'd10;
        rd(3'd0, v); check("R5 13 cycles per tick", v, model);
    endtask

    task automatic t_gate;
        logic [31:0] v;
        wr(3'd4, 32'h0000_000C);
        run_en(12);
        rd(3'd0, v); check("R6 no tick before 13", v, model);
        repeat (40) @(negedge clk);
        rd(3'd0, v); check("R6 gated count frozen", v, model);
        run_en(1);
        model = model + 32'd1;
        rd(3'd0, v); check("R6 phase held while gated", v, model);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        wr(3'd4, 32'h0000_000C);
        run_en(12);
        wr(3'd4, 32'h0000_000C);
        run_en(12);
        rd(3'd0, v); check("R7 phase cleared by write", v, model);
        run_en(1);
        model = model + 32'd1;
        rd(3'd0, v); check("R7 tick after fresh 13", v, model);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        int n;
        n = int'(32'h0 - model);
        rate_case("R8 saturate q>w", 16'h0100, n);
        check("R9 wrapped to zero", model, 32'h0);
        rate_case("R9 runs after wrap", 16'h0500, 3);
        rate_case("R8 saturate 3/2", 16'h0201, 40);
        rate_case("R11 one per cycle at q=w", 16'h0707, 25);
        v = model;
        check("R11 count equals cycles", v, 32'd68);
    endtask

    task automatic t_rates;
        rate_case("R4 19.2 MHz", 16'h045F, 960);
        rate_case("R4 38.4 MHz", 16'h04BF, 1920);
        rate_case("R4 16.8 MHz", 16'h0453, 840);
        rate_case("R4 38.4 MHz partial", 16'h04BF, 700);
        rate_case("R3 12 MHz", 16'h000B, 1200);
        rate_case("R3 26 MHz", 16'h0019, 2600);
        rate_case("R3 48 MHz", 16'h002F, 4800);
        rate_case("R2 generic 3/7", 16'h0206, 101);
        rate_case("R2 generic 19.2 partial", 16'h045F, 1001);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_default();
        t_gate();
        t_clear();
        t_wrap();
        t_rates();
        finish_run();
    end
endmodule